// File: doc/BRIEF.md
# Windowed Watchdog Reset Supervisor

This block supervises a processor from power-up onwards. While the external supply-good indication is low, the block holds the processor in reset. Once supply-good rises, it keeps reset asserted for a power-on delay. After that it runs a repeating watchdog cycle. Each cycle is a closed window followed by an open window, and software must service the block inside the open window. A service that comes too early (inside the closed window) or not at all produces a short reset pulse, and a fresh cycle then begins with a closed window.

A second active-low output, the system enable, gates critical functions such as motor drivers. It is off whenever reset is active. After any reset or supply loss it stays off until software has placed three consecutive services inside open windows. A system that keeps crashing is therefore never given control of those functions.

All durations are counted in ticks of a timebase enable input. One parameter sets the nominal watchdog time, and every other duration is derived from it. Two further parameters pick which window is the long one and shorten the power-on delay.

Top module: `window_watchdog`

## Requirements
- R1: While `supplyOk` is low, `resetN` is low. The release happens at the rising clock edge that is the POR-th edge with both `supplyOk` and `tick` high, where POR = `WD_TICKS`, or `WD_TICKS/4` when `QUARTER_POR` is 1. The rising edge of the asynchronous `rstN` starts the block in this power-on state.
- R2: The long window lasts `4*WD_TICKS/5` ticks and the short window lasts `2*WD_TICKS/5` ticks. With `CLOSED_LONG` = 1 the closed window is the long one; with `CLOSED_LONG` = 0 the closed window is the short one.
- R3: With no service, `resetN` stays high for closed plus open ticks and then low for the pulse width, `max(1, WD_TICKS/40)` ticks. This pattern repeats indefinitely.
- R4: A falling edge of `serviceIn` acts at the third rising clock edge after the pin falls. If that edge lies inside the open window, including its last tick, a new closed window starts and `resetN` stays high. At the last open tick, the service takes priority over the timeout.
- R5: If that edge lies inside the closed window, including its last tick, `resetN` goes low for the pulse width and a new closed window then follows. At the last closed tick, the violation takes priority over the move to the open window.
- R6: When `supplyOk` is sampled low, `resetN` is low and `enableN` is high from the next clock edge, whatever the watchdog state.
- R7: Services that arrive while `supplyOk` is low or during the power-on delay have no effect; the delay length is unchanged.
- R8: `enableN` is high whenever `resetN` is low. It goes low after the third consecutive open-window service and stays low on further services. A closed-window service, a timeout or a supply loss restarts the count from zero.
- R9: A rising edge of `serviceIn` has no effect in either window.
- R10: Clock edges with `tick` low do not advance any duration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low initialisation; enters the power-on state |
| tick | input | 1 | Timebase enable; one tick per cycle in which it is high |
| supplyOk | input | 1 | Supply-good level, already synchronous to `clk` |
| serviceIn | input | 1 | Service request from the processor, asynchronous, acts on its falling edge |
| resetN | output | 1 | Active-low processor reset |
| enableN | output | 1 | Active-low system enable |

## Verification
Two functions meet in the same cycle at the window boundaries. A service can become effective on the very tick where the closed window expires, or on the very tick where the open window times out. The bench places the service falling edge so that its third clock edge lands exactly on the last closed tick, the first open tick and the last open tick. It then judges the outcome from the lengths of the high and low phases of `resetN` that follow: a pulse where the violation must win, and no pulse where the service must win. A third collision, a supply drop coinciding with service activity, is judged by the reset phase length and the enable level immediately after the drop.

// File: rtl/wwd_pkg.sv
package wwd_pkg;

  typedef enum logic [1:0] {
    ST_POR    = 2'd0,
    ST_CLOSED = 2'd1,
    ST_OPEN   = 2'd2,
    ST_PULSE  = 2'd3
  } wdState_t;

  // Strobes sent from the control FSM to the datapath every cycle.
  typedef struct packed {
    logic     timerClr;
    logic     svcClr;
    logic     svcInc;
    wdState_t phase;
  } wdStrobes_t;

endpackage

// File: rtl/wwd_datapath.sv
module wwd_datapath
  import wwd_pkg::*;
#(
  parameter int WD_TICKS    = 80,
  parameter bit CLOSED_LONG = 1'b1,
  parameter bit QUARTER_POR = 1'b0,
  parameter int SVC_NEEDED  = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic       serviceIn,
  input  wdStrobes_t strobes,
  output logic       timerDone,
  output logic       svcFall,
  output logic       svcFull
);

  localparam int LONG_T   = (WD_TICKS * 4) / 5;
  localparam int SHORT_T  = (WD_TICKS * 2) / 5;
  localparam int CLOSED_T = CLOSED_LONG ? LONG_T : SHORT_T;
  localparam int OPEN_T   = CLOSED_LONG ? SHORT_T : LONG_T;
  localparam int PULSE_T  = (WD_TICKS / 40 < 1) ? 1 : WD_TICKS / 40;
  localparam int CW       = $clog2(WD_TICKS + 1);
  localparam int SCW      = $clog2(SVC_NEEDED + 1);

  logic [CW-1:0]  porLimit;
  logic [CW-1:0]  limit;
  logic [CW-1:0]  tmr;
  logic           svcMeta, svcSync, svcPrev;
  logic [SCW-1:0] svcCnt;

  // Power-on delay length: full watchdog time or a quarter of it.
  generate
    if (QUARTER_POR) begin : g_porQuarter
      assign porLimit = CW'((WD_TICKS / 4 < 1) ? 1 : WD_TICKS / 4);
    end else begin : g_porFull
      assign porLimit = CW'(WD_TICKS);
    end
  endgenerate

  always_comb begin
    unique case (strobes.phase)
      ST_POR:    limit = porLimit;
      ST_CLOSED: limit = CW'(CLOSED_T);
      ST_OPEN:   limit = CW'(OPEN_T);
      default:   limit = CW'(PULSE_T);
    endcase
  end

  assign timerDone = tick && (tmr == limit - CW'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tmr <= '0;
    end else if (strobes.timerClr) begin
      tmr <= '0;
    end else if (tick) begin
      tmr <= tmr + CW'(1);
    end
  end

  // Two-stage synchronizer plus one history stage for edge detection.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      svcMeta <= 1'b1;
      svcSync <= 1'b1;
      svcPrev <= 1'b1;
    end else begin
      svcMeta <= serviceIn;
      svcSync <= svcMeta;
      svcPrev <= svcSync;
    end
  end

  assign svcFall = svcPrev && !svcSync;

  // Consecutive good-service counter, saturating at SVC_NEEDED.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      svcCnt <= '0;
    end else if (strobes.svcClr) begin
      svcCnt <= '0;
    end else if (strobes.svcInc && (svcCnt != SCW'(SVC_NEEDED))) begin
      svcCnt <= svcCnt + SCW'(1);
    end
  end

  assign svcFull = (svcCnt == SCW'(SVC_NEEDED));

endmodule

// File: rtl/wwd_control.sv
module wwd_control
  import wwd_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       supplyOk,
  input  logic       timerDone,
  input  logic       svcFall,
  input  logic       svcFull,
  output wdStrobes_t strobes,
  output logic       resetN,
  output logic       enableN
);

  wdState_t state, nextState;

  always_comb begin
    nextState        = state;
    strobes.timerClr = 1'b0;
    strobes.svcClr   = 1'b0;
    strobes.svcInc   = 1'b0;
    strobes.phase    = state;
    if (!supplyOk) begin
      // Supply loss overrides everything and restarts the power-on delay.
      nextState        = ST_POR;
      strobes.timerClr = 1'b1;
      strobes.svcClr   = 1'b1;
    end else begin
      unique case (state)
        ST_POR: begin
          if (timerDone) begin
            nextState        = ST_CLOSED;
            strobes.timerClr = 1'b1;
          end
        end
        ST_CLOSED: begin
          if (svcFall) begin
            // Early service wins over the closed-window expiry.
            nextState        = ST_PULSE;
            strobes.timerClr = 1'b1;
            strobes.svcClr   = 1'b1;
          end else if (timerDone) begin
            nextState        = ST_OPEN;
            strobes.timerClr = 1'b1;
          end
        end
        ST_OPEN: begin
          if (svcFall) begin
            // Good service wins over the open-window timeout.
            nextState        = ST_CLOSED;
            strobes.timerClr = 1'b1;
            strobes.svcInc   = 1'b1;
          end else if (timerDone) begin
            nextState        = ST_PULSE;
            strobes.timerClr = 1'b1;
            strobes.svcClr   = 1'b1;
          end
        end
        default: begin
          if (timerDone) begin
            nextState        = ST_CLOSED;
            strobes.timerClr = 1'b1;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_POR;
    end else begin
      state <= nextState;
    end
  end

  assign resetN  = (state == ST_CLOSED) || (state == ST_OPEN);
  assign enableN = !(resetN && svcFull);

endmodule

// File: rtl/window_watchdog.sv
module window_watchdog
  import wwd_pkg::*;
#(
  parameter int WD_TICKS    = 80,
  parameter bit CLOSED_LONG = 1'b1,
  parameter bit QUARTER_POR = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic tick,
  input  logic supplyOk,
  input  logic serviceIn,
  output logic resetN,
  output logic enableN
);

  localparam int SVC_NEEDED = 3;

  wdStrobes_t strobes;
  logic       timerDone;
  logic       svcFall;
  logic       svcFull;

  wwd_datapath #(
    .WD_TICKS   (WD_TICKS),
    .CLOSED_LONG(CLOSED_LONG),
    .QUARTER_POR(QUARTER_POR),
    .SVC_NEEDED (SVC_NEEDED)
  ) u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .tick     (tick),
    .serviceIn(serviceIn),
    .strobes  (strobes),
    .timerDone(timerDone),
    .svcFall  (svcFall),
    .svcFull  (svcFull)
  );

  wwd_control u_control (
    .clk      (clk),
    .rstN     (rstN),
    .supplyOk (supplyOk),
    .timerDone(timerDone),
    .svcFall  (svcFall),
    .svcFull  (svcFull),
    .strobes  (strobes),
    .resetN   (resetN),
    .enableN  (enableN)
  );

endmodule

// File: rtl/wwd_checker.sv
module wwd_checker #(
  parameter int WD_TICKS = 80
) (
  input logic clk,
  input logic rstN,
  input logic supplyOk,
  input logic resetN,
  input logic enableN
);

  localparam int PULSE_T = (WD_TICKS / 40 < 1) ? 1 : WD_TICKS / 40;

  logic [15:0] lowRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowRun <= '0;
    end else if (!resetN) begin
      if (lowRun != 16'hFFFF) lowRun <= lowRun + 16'd1;
    end else begin
      lowRun <= '0;
    end
  end

  assert_enable_off_in_reset_R8: assert property (@(posedge clk) disable iff (!rstN)
    !resetN |-> enableN);

  assert_drop_forces_reset_R6: assert property (@(posedge clk) disable iff (!rstN)
    !supplyOk |=> (!resetN && enableN));

  assert_release_needs_supply_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(resetN) |-> $past(supplyOk));

  assert_enable_only_while_running_R8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(enableN) |-> ($past(resetN) && resetN));

  assert_min_pulse_width_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(resetN) |-> (lowRun >= 16'(PULSE_T)));

endmodule

bind window_watchdog wwd_checker #(.WD_TICKS(WD_TICKS)) u_wwdChecker (
  .clk     (clk),
  .rstN    (rstN),
  .supplyOk(supplyOk),
  .resetN  (resetN),
  .enableN (enableN)
);

// File: tb/test_window_watchdog.sv
`timescale 1ns/1ps
module test_window_watchdog;

  localparam int CLOSED_CYC = 64;  // WD_TICKS = 80, long closed window
  localparam int OPEN_CYC   = 32;
  localparam int CYCLE_CYC  = CLOSED_CYC + OPEN_CYC;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tick = 1'b1, supplyOk = 1'b0, serviceIn = 1'b1;
  logic resetN, enableN;
  logic tick2 = 1'b1, supply2 = 1'b0, service2 = 1'b1;
  logic resetN2, enableN2;

  always #2 clk = ~clk;

  window_watchdog #(.WD_TICKS(80), .CLOSED_LONG(1'b1), .QUARTER_POR(1'b0)) i_window_watchdog (
    .clk(clk), .rstN(rstN), .tick(tick), .supplyOk(supplyOk),
    .serviceIn(serviceIn), .resetN(resetN), .enableN(enableN));

  window_watchdog #(.WD_TICKS(80), .CLOSED_LONG(1'b0), .QUARTER_POR(1'b1)) i_window_watchdog_alt (
    .clk(clk), .rstN(rstN), .tick(tick2), .supplyOk(supply2),
    .serviceIn(service2), .resetN(resetN2), .enableN(enableN2));

  typedef struct {
    bit    lvl;
    int    len;
    string req;
  } phase_t;

  phase_t expQ[$];
  int checks = 0;
  int fails = 0;
  int run = 1;      // high negedges so far in the ongoing high phase
  int pos = 1;      // position inside the current closed+open cycle
  int goodSvc = 0;  // modelled consecutive good services
  bit done = 1'b0;
  bit altDone = 1'b0;

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pushPhase(bit lvl, int len, string req);
    expQ.push_back('{lvl, len, req});
  endtask

  // Monitor: measures each resetN phase and compares it with the queue.
  bit curLvl = 1'b0;
  int runLen = 0;
  always @(negedge clk) begin
    if (!done) begin
      if (resetN == curLvl) begin
        runLen++;
      end else begin
        if (expQ.size() == 0) begin
          check(1'b0, "R3 unexpected phase end", runLen, 0);
        end else begin
          phase_t e;
          e = expQ.pop_front();
          check((e.lvl == curLvl) && (e.len == runLen),
                $sformatf("%s phase level=%0d length", e.req, curLvl), runLen, e.len);
        end
        curLvl = resetN;
        runLen = 1;
      end
    end
  end

  task automatic checkEnable(string req);
    check(enableN == (goodSvc < 3), req, enableN, (goodSvc < 3));
  endtask

  // From the current negedge, wait k negedges and then drop serviceIn.
  task automatic serve(int k, string req);
    int j;
    j = pos + k + 2;
    if (j <= CLOSED_CYC) begin
      pushPhase(1'b1, run + k + 2, req);
      pushPhase(1'b0, 2, req);
      goodSvc = 0;
    end else begin
      goodSvc = (goodSvc < 3) ? goodSvc + 1 : 3;
    end
    repeat (k) @(negedge clk);
    serviceIn = 1'b0;
    repeat (2) @(negedge clk);
    serviceIn = 1'b1;
    if (j <= CLOSED_CYC) begin
      repeat (3) @(negedge clk);
      run = 1;
    end else begin
      repeat (1) @(negedge clk);
      run = run + k + 3;
    end
    pos = 1;
    checkEnable($sformatf("%s enable after service", req));
  endtask

  task automatic runTimeout(string req);
    pushPhase(1'b1, run + CYCLE_CYC - pos, req);
    pushPhase(1'b0, 2, req);
    repeat (CYCLE_CYC - pos) @(negedge clk);
    repeat (3) @(negedge clk);
    run = 1;
    pos = 1;
    goodSvc = 0;
    checkEnable("R8 enable after timeout");
  endtask

  task automatic finishRun();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin : watchdogTimer
    repeat (20000) @(negedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    finishRun();
  end

  // Second instance: short closed window, quarter power-on delay, gated tick.
  initial begin : altStimulus
    repeat (7) @(negedge clk);
    supply2 = 1'b1;
    repeat (3) @(negedge clk);
    tick2 = 1'b0;
    repeat (10) @(negedge clk);
    tick2 = 1'b1;
    repeat (16) @(negedge clk);
    check(resetN2 == 1'b0, "R10 delay held while tick low", resetN2, 0);
    repeat (1) @(negedge clk);
    check(resetN2 == 1'b1, "R1 quarter delay release", resetN2, 1);
    repeat (37) @(negedge clk);
    service2 = 1'b0;
    repeat (2) @(negedge clk);
    service2 = 1'b1;
    repeat (1) @(negedge clk);
    check(resetN2 == 1'b1, "R2 short closed window then open", resetN2, 1);
    check(enableN2 == 1'b1, "R8 one service keeps enable off", enableN2, 1);
    repeat (26) @(negedge clk);
    service2 = 1'b0;
    repeat (2) @(negedge clk);
    service2 = 1'b1;
    repeat (1) @(negedge clk);
    check(resetN2 == 1'b0, "R2 short closed window violation", resetN2, 0);
    altDone = 1'b1;
  end

  initial begin : mainStimulus
    pushPhase(1'b0, 88, "R1");
    repeat (2) @(negedge clk);
    check(resetN == 1'b0, "R1 reset state resetN", resetN, 0);
    check(enableN == 1'b1, "R8 reset state enableN", enableN, 1);
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    supplyOk = 1'b1;
    repeat (11) @(negedge clk);
    serviceIn = 1'b0;            // R7: ignored during the power-on delay
    repeat (2) @(negedge clk);
    serviceIn = 1'b1;
    repeat (67) @(negedge clk);
    check(resetN == 1'b1, "R1 release after delay", resetN, 1);

    runTimeout("R3");
    runTimeout("R3");

    serve(61, "R5");             // lands on the last closed tick
    serve(62, "R4");             // first open tick
    serve(93, "R4");             // last open tick

    // R9: good service held low, then released inside the closed window.
    goodSvc = 3;
    repeat (62) @(negedge clk);
    serviceIn = 1'b0;
    repeat (3) @(negedge clk);
    run = run + 65;
    repeat (9) @(negedge clk);
    serviceIn = 1'b1;
    repeat (5) @(negedge clk);
    run = run + 14;
    pos = 15;
    check(resetN == 1'b1, "R9 rising edge ignored", resetN, 1);
    checkEnable("R8 enable after third service");

    serve(70, "R8");             // saturation
    serve(10, "R5");             // early service clears the count
    serve(70, "R8");
    serve(70, "R8");
    serve(70, "R8");
    runTimeout("R3");
    serve(70, "R4");

    // R6/R7: supply drop with service activity during low supply and delay.
    repeat (20) @(negedge clk);
    supplyOk = 1'b0;
    pushPhase(1'b1, run + 20, "R6");
    repeat (1) @(negedge clk);
    check(resetN == 1'b0, "R6 reset forced on drop", resetN, 0);
    check(enableN == 1'b1, "R6 enable off on drop", enableN, 1);
    serviceIn = 1'b0;
    repeat (2) @(negedge clk);
    serviceIn = 1'b1;
    repeat (7) @(negedge clk);
    supplyOk = 1'b1;
    pushPhase(1'b0, 89, "R7");
    repeat (10) @(negedge clk);
    serviceIn = 1'b0;
    repeat (2) @(negedge clk);
    serviceIn = 1'b1;
    repeat (68) @(negedge clk);
    run = 1;
    pos = 1;
    goodSvc = 0;
    check(resetN == 1'b1, "R1 release after supply returns", resetN, 1);
    checkEnable("R8 enable off after supply loss");

    runTimeout("R3");
    repeat (3) @(negedge clk);
    check(expQ.size() == 0, "R3 all expected phases seen", expQ.size(), 0);
    wait (altDone);
    @(negedge clk);
    finishRun();
  end

endmodule